// File: doc/BRIEF.md
# Range-Match Translation Buffer

This block is a small, fully associative address translation cache. Each of its slots holds an inclusive virtual range (first and last address), a physical page number, a 29-bit protection word and a valid flag. A lookup port takes a virtual address every cycle. One cycle later it reports whether any slot covers that address. On a hit it also reports which slot matched, the physical address, the slot's valid flag and its protection word. When several slots cover the address, the lowest index wins. The valid flag plays no part in matching.

A slot is filled in two steps through one command port that accepts one command per cycle. An address insert places a page-aligned 4 KiB range and a physical page number in a slot and leaves it invalid. A protection insert then loads the rights word into the covering slot and marks it valid. Two purge commands remove translations: one removes a single page, the other removes every slot. A round-robin pointer picks the victim when an address insert finds no slot covering its address. A slot that has been emptied holds first address all ones and last address zero, so it can never match.

Top module: `range_tlb`

## Requirements
- R1: While reset is asserted and just after it, every slot is empty, the round-robin pointer is 0, and all lookup outputs and `cmd_err` are 0.
- R2: The lookup result is registered. For the address presented in cycle n, the outputs in cycle n+1 show the lowest-index slot with first <= address <= last, taken from the table as it stood in cycle n, whether or not that slot is valid. On a hit, `lk_pa` = {ppn, address[11:0]}, `lk_valid` is the slot's valid flag and `lk_prot` is its protection word. On a miss, hit, index, address, valid and protection are all 0.
- R3: An address insert writes the range first = address with bits [11:0] cleared, last = first + 4095. The physical page number comes from data bits [24:5]. The slot's valid flag is left at 0.
- R4: When no slot covers the inserted address, the slot at the round-robin pointer is emptied and used. Only in that case does the pointer advance by one, and it wraps from 15 to 0.
- R5: An address insert empties every valid slot that covers the address. It then reuses the lowest-index covering slot, whether that slot is valid or not, and leaves the pointer unchanged. An invalid covering slot that is reused keeps its protection word.
- R6: A protection insert copies data bits [29:1] into the protection word of the lowest-index covering slot and sets its valid flag. In `lk_prot` the layout is: [17:0] access id, [18] U, [20:19] PL2, [22:21] PL1, [25:23] type, [26] B, [27] D, [28] T.
- R7: A protection insert that finds no covering slot changes no slot. `cmd_err` goes high for exactly the cycle after that command. `cmd_err` is 0 after every other command.
- R8: A single-page purge empties the lowest-index covering slot if it is valid. If that slot is invalid, or no slot covers the address, the table is left unchanged.
- R9: A purge-all command empties every slot in one cycle.
- R10: An emptied slot matches no address, including 0xFFFFFFFF.

Opcodes on `cmd_op`: 0 address insert, 1 protection insert, 2 single-page purge, 3 purge all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_vld | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command opcode |
| cmd_va | input | 32 | Virtual address the command applies to |
| cmd_data | input | 32 | Operand for the insert commands |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | A slot covered the previous cycle's lookup address |
| lk_idx | output | 4 | Index of the matching slot |
| lk_pa | output | 32 | Translated physical address |
| lk_valid | output | 1 | Valid flag of the matching slot |
| lk_prot | output | 29 | Protection word of the matching slot |
| cmd_err | output | 1 | Pulse: a protection insert found no covering slot |

## Verification
The lookup result and `cmd_err` for the inputs of cycle n are both due at the first rising edge after cycle n. A command changes the table at that same edge, so a lookup presented in the cycle after a command is the first to see its effect. The bench drives inputs just after a falling edge and samples the outputs at the next falling edge, so exactly one register edge lies in between. Its reference model forms the expected lookup from the table before the command, and only then applies the command. This keeps the bench correct when a lookup and a command fall in the same cycle.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

    localparam int VA_W     = 32;
    localparam int PG_BITS  = 12;
    localparam int PPN_W    = 20;
    localparam int PPN_LSB  = 5;
    localparam int PROT_W   = 29;
    localparam int PROT_LSB = 1;
    localparam int DATA_W   = 32;
    localparam int PA_W     = PPN_W + PG_BITS;

    typedef enum logic [1:0] {
        OP_ADDR_INS  = 2'd0,
        OP_PROT_INS  = 2'd1,
        OP_PURGE_PG  = 2'd2,
        OP_PURGE_ALL = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic [VA_W-1:0]   vbeg;
        logic [VA_W-1:0]   vend;
        logic [PPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
        logic              valid;
    } tlb_ent_t;

    // An emptied slot: first address all ones, last address zero.
    function automatic tlb_ent_t empty_ent();
        tlb_ent_t e;
        e       = '0;
        e.vbeg  = '1;
        return e;
    endfunction

endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match
    import range_tlb_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  tlb_ent_t [NUM_ENT-1:0] ents,
    input  logic [VA_W-1:0]        va,
    output logic [NUM_ENT-1:0]     hits
);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign hits[g] = (ents[g].vbeg <= va) && (va <= ents[g].vend);
    end

endmodule

// File: rtl/range_tlb_first.sv
module range_tlb_first #(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/range_tlb.sv
module range_tlb
    import range_tlb_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [1:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_valid,
    output logic [PROT_W-1:0] lk_prot,
    output logic              cmd_err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);
    localparam logic [VA_W-1:0]  PG_MASK  = VA_W'((64'd1 << PG_BITS) - 64'd1);

    typedef struct packed {
        tlb_ent_t [NUM_ENT-1:0] ent;
        logic [IDX_W-1:0]       rr;
        logic                   lk_hit;
        logic [IDX_W-1:0]       lk_idx;
        logic [PA_W-1:0]        lk_pa;
        logic                   lk_vld;
        logic [PROT_W-1:0]      lk_prot;
        logic                   err;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            s.ent[i] = empty_ent();
        end
        return s;
    endfunction

    state_t st_q, st_d;

    logic [NUM_ENT-1:0] lk_hits, cmd_hits;
    logic               lk_any, cmd_any;
    logic [IDX_W-1:0]   lk_first, cmd_first;
    logic [IDX_W-1:0]   tgt;
    logic [VA_W-1:0]    page_base;
    tlb_op_e            op;
    logic               unused_data;

    assign op          = tlb_op_e'(cmd_op);
    assign page_base   = cmd_va & ~PG_MASK;
    assign unused_data = ^{cmd_data[DATA_W-1:PROT_LSB+PROT_W], cmd_data[0]};

    range_tlb_match #(.NUM_ENT(NUM_ENT)) u_lk_match (
        .ents (st_q.ent),
        .va   (lk_va),
        .hits (lk_hits)
    );

    range_tlb_match #(.NUM_ENT(NUM_ENT)) u_cmd_match (
        .ents (st_q.ent),
        .va   (cmd_va),
        .hits (cmd_hits)
    );

    range_tlb_first #(.NUM_ENT(NUM_ENT)) u_lk_first (
        .req (lk_hits),
        .any (lk_any),
        .idx (lk_first)
    );

    range_tlb_first #(.NUM_ENT(NUM_ENT)) u_cmd_first (
        .req (cmd_hits),
        .any (cmd_any),
        .idx (cmd_first)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        tgt      = cmd_first;

        // Lookup result, taken from the table before this cycle's command.
        st_d.lk_hit = lk_any;
        if (lk_any) begin
            st_d.lk_idx  = lk_first;
            st_d.lk_pa   = {st_q.ent[lk_first].ppn, lk_va[PG_BITS-1:0]};
            st_d.lk_vld  = st_q.ent[lk_first].valid;
            st_d.lk_prot = st_q.ent[lk_first].prot;
        end else begin
            st_d.lk_idx  = '0;
            st_d.lk_pa   = '0;
            st_d.lk_vld  = 1'b0;
            st_d.lk_prot = '0;
        end

        if (cmd_vld) begin
            unique case (op)
                OP_ADDR_INS: begin
                    for (int i = 0; i < NUM_ENT; i++) begin
                        if (cmd_hits[i] && st_q.ent[i].valid) begin
                            st_d.ent[i] = empty_ent();
                        end
                    end
                    if (!cmd_any) begin
                        tgt              = st_q.rr;
                        st_d.ent[st_q.rr] = empty_ent();
                        st_d.rr          = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
                    end
                    st_d.ent[tgt].vbeg  = page_base;
                    st_d.ent[tgt].vend  = page_base | PG_MASK;
                    st_d.ent[tgt].ppn   = cmd_data[PPN_LSB +: PPN_W];
                    st_d.ent[tgt].valid = 1'b0;
                end
                OP_PROT_INS: begin
                    if (cmd_any) begin
                        st_d.ent[cmd_first].prot  = cmd_data[PROT_LSB +: PROT_W];
                        st_d.ent[cmd_first].valid = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_PURGE_PG: begin
                    if (cmd_any && st_q.ent[cmd_first].valid) begin
                        st_d.ent[cmd_first] = empty_ent();
                    end
                end
                OP_PURGE_ALL: begin
                    for (int i = 0; i < NUM_ENT; i++) begin
                        st_d.ent[i] = empty_ent();
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_hit   = st_q.lk_hit;
    assign lk_idx   = st_q.lk_idx;
    assign lk_pa    = st_q.lk_pa;
    assign lk_valid = st_q.lk_vld;
    assign lk_prot  = st_q.lk_prot;
    assign cmd_err  = st_q.err;

    logic [NUM_ENT-1:0] valid_vec;
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_vld
        assign valid_vec[g] = st_q.ent[g].valid;
    end

    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[PG_BITS-1:0] == $past(lk_va[PG_BITS-1:0])); // R2

    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.rr) |-> ($past(cmd_vld && cmd_op == OP_ADDR_INS) &&
            st_q.rr == (($past(st_q.rr) == LAST_IDX) ? '0 : IDX_W'($past(st_q.rr) + 1'b1)))); // R4

    AST_PINS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == OP_PROT_INS && cmd_any) |=> valid_vec[$past(cmd_first)]); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_vld && cmd_op == OP_PROT_INS && !cmd_any)); // R7

    AST_PALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == OP_PURGE_ALL) |=> (valid_vec == '0)); // R9

endmodule

// File: tb/range_tlb_bench.sv
module range_tlb_bench;

    localparam int CLK_P = 10;
    localparam int N     = 16;
    localparam logic [1:0] AINS = 2'd0, PINS = 2'd1, PPG = 2'd2, PALL = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_va = '0, cmd_data = '0, lk_va = '0;
    logic        lk_hit, lk_valid, cmd_err;
    logic [3:0]  lk_idx;
    logic [31:0] lk_pa;
    logic [28:0] lk_prot;

    int errors = 0;
    int checks = 0;

    logic [31:0] mb [N];
    logic [31:0] me [N];
    logic [19:0] mp [N];
    logic [28:0] mr [N];
    logic        mv [N];
    int          mrr;

    always #(CLK_P/2) clk = ~clk;

    range_tlb u_range_tlb (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_va(cmd_va), .cmd_data(cmd_data), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pa(lk_pa),
        .lk_valid(lk_valid), .lk_prot(lk_prot), .cmd_err(cmd_err)
    );

    function automatic int first_cover(logic [31:0] a);
        for (int i = 0; i < N; i++) begin
            if (mb[i] <= a && a <= me[i]) return i;
        end
        return -1;
    endfunction

    function automatic void clear_slot(int i);
        mb[i] = '1; me[i] = '0; mp[i] = '0; mr[i] = '0; mv[i] = 1'b0;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(string tag, string what, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample at the next falling edge.
    task automatic step(logic v, logic [1:0] op, logic [31:0] va, logic [31:0] d,
                        logic [31:0] la, string tag);
        int f;
        logic [95:0] exp_lk;
        logic        exp_err;
        cmd_vld = v; cmd_op = op; cmd_va = va; cmd_data = d; lk_va = la;
        f = first_cover(la);
        if (f >= 0) exp_lk = {1'b1, 4'(f), mp[f], la[11:0], mv[f], mr[f]};
        else        exp_lk = '0;
        exp_err = 1'b0;
        f = first_cover(va);
        if (v) begin
            case (op)
                AINS: begin
                    for (int i = 0; i < N; i++)
                        if (mb[i] <= va && va <= me[i] && mv[i]) clear_slot(i);
                    if (f < 0) begin
                        f = mrr; clear_slot(f);
                        mrr = (mrr == N - 1) ? 0 : mrr + 1;
                    end
                    mb[f] = {va[31:12], 12'h000};
                    me[f] = {va[31:12], 12'hFFF};
                    mp[f] = d[24:5];
                    mv[f] = 1'b0;
                end
                PINS: begin
                    if (f >= 0) begin mr[f] = d[29:1]; mv[f] = 1'b1; end
                    else exp_err = 1'b1;
                end
                PPG: if (f >= 0 && mv[f]) clear_slot(f);
                default: for (int i = 0; i < N; i++) clear_slot(i);
            endcase
        end
        @(negedge clk);
        check(tag, "lookup", {lk_hit, lk_idx, lk_pa, lk_valid, lk_prot}, exp_lk);
        check(tag, "cmd_err", {95'd0, cmd_err}, {95'd0, exp_err});
        cmd_vld = 1'b0;
    endtask

    function automatic logic [31:0] rnd_va();
        if ($urandom_range(0, 19) == 0) return 32'hFFFF_FFFF;
        return 32'h0040_0000 + ($urandom_range(0, 23) << 12) + $urandom_range(0, 4095);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) clear_slot(i);
        mrr = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", "reset", {lk_hit, lk_idx, lk_pa, lk_valid, lk_prot, cmd_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "after reset", {lk_hit, lk_idx, lk_pa, lk_valid, lk_prot, cmd_err}, '0);

        step(1'b0, AINS, 0, 0, 32'hFFFF_FFFF, "R10");
        step(1'b1, AINS, 32'h1234_5678, 32'(20'hABCDE) << 5, 32'h0, "R3");
        step(1'b0, AINS, 0, 0, 32'h1234_5FFF, "R3");
        step(1'b1, PINS, 32'h1234_5000, 32'h3FFF_FFFE, 32'h1234_5000, "R2");
        step(1'b0, AINS, 0, 0, 32'h1234_5001, "R6");
        step(1'b1, PINS, 32'h9000_0000, 32'h1555_5554, 32'h9000_0000, "R7");
        step(1'b0, AINS, 0, 0, 32'h1234_5002, "R7");
        for (int k = 1; k <= 16; k++)
            step(1'b1, AINS, 32'h2000_0000 + (k << 12), k << 5, 32'h1234_5000, "R4");
        step(1'b0, AINS, 0, 0, 32'h1234_5000, "R4");
        step(1'b0, AINS, 0, 0, 32'h2001_0010, "R4");
        step(1'b1, PINS, 32'h2000_5000, 32'h2AAA_AAAA, 32'h2000_5000, "R6");
        step(1'b1, AINS, 32'h2000_5123, 32'h00FF_FFE0, 32'h2000_5123, "R5");
        step(1'b0, AINS, 0, 0, 32'h2000_5FFF, "R5");
        step(1'b1, PINS, 32'h2000_7000, 32'h0000_0F0E, 32'h0, "R6");
        step(1'b1, AINS, 32'h2000_7ABC, 32'h0000_0100, 32'h2000_7000, "R5");
        step(1'b1, AINS, 32'h3000_0000, 32'h0000_0200, 32'h2000_7000, "R5");
        step(1'b0, AINS, 0, 0, 32'h3000_0000, "R4");
        step(1'b1, PPG, 32'h2000_5000, 0, 32'h0, "R8");
        step(1'b0, AINS, 0, 0, 32'h2000_5000, "R8");
        step(1'b1, PINS, 32'h2000_5000, 32'h2000_0002, 32'h0, "R8");
        step(1'b1, PPG, 32'h2000_5000, 0, 32'h2000_5000, "R8");
        step(1'b0, AINS, 0, 0, 32'h2000_5000, "R8");
        step(1'b1, PALL, 0, 0, 32'h2000_3000, "R9");
        step(1'b0, AINS, 0, 0, 32'h2000_3000, "R9");
        step(1'b0, AINS, 0, 0, 32'hFFFF_FFFF, "R10");

        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [1:0] op;
            sel = $urandom_range(0, 99);
            op  = (sel < 45) ? AINS : (sel < 80) ? PINS : (sel < 97) ? PPG : PALL;
            step(1'($urandom_range(0, 3) != 0), op, rnd_va(), $urandom(), rnd_va(), "R2");
        end

        report();
        $finish;
    end

endmodule